// File: doc/BRIEF.md
# Stack and Next-PC Control Unit

This block steers a one-instruction-per-cycle datapath through the stack instructions and the immediate load. It takes a decoded opcode, one register specifier, an immediate, and the fall-through PC. From these it chooses which registers to read, which registers to write and through which write port, and what to present to data memory: address, write data and write enable. It also picks the PC for the next instruction.

The block holds a small register file. Register 4 is the stack pointer. Register number 0xF means "no register". Data memory lives outside the block. Its read data must come back in the same cycle as the address. Register and memory writes take effect on the rising clock edge.

The stack grows downward in steps of 8. Push and call use the decremented stack pointer produced by the ALU as the memory address. Pop and return use the stack pointer as it was before the instruction.

Top module: `stk_ctl`

## Requirements
- R1: On reset, register 4 (the stack pointer) holds `SP_RESET` (default 0x200) and every other register holds 0.
- R2: Load-immediate (opcode 1) reads no register and writes `imm_i` into the register named by `reg_i`. Its memory address and write data are 0, memory write is off, and the next PC is `fall_pc_i`.
- R3: Push (opcode 2) presents address SP−8, write data equal to the value of register `reg_i` before the instruction (the old SP when `reg_i` is 4), and write enable 1. It leaves SP−8 in register 4.
- R4: Pop (opcode 3) presents address SP (the old value) with write enable 0. It writes `mem_rdata_i` into register `reg_i` and SP+8 into register 4, both on the same edge.
- R5: When pop names register 4, the memory value wins, and register 4 ends up holding `mem_rdata_i`.
- R6: Call (opcode 4) presents address SP−8, write data `fall_pc_i`, and write enable 1. Its next PC is `imm_i`, and register 4 becomes SP−8.
- R7: Return (opcode 5) presents address SP (the old value) with write enable 0. Its next PC is `mem_rdata_i`, and register 4 becomes SP+8.
- R8: Memory write enable is 1 only for push and call. The next PC is `fall_pc_i` for every opcode except call and return.
- R9: A write aimed at register 0xF changes no register. This covers load-immediate or pop with `reg_i` = 0xF.
- R10: Opcode 0 and the unused opcodes 6 and 7 change no register and drive address 0, write data 0, and write enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded opcode: 0 none, 1 load-imm, 2 push, 3 pop, 4 call, 5 return |
| reg_i | input | 4 | Register specifier (0xF = none) |
| imm_i | input | DW | Instruction immediate |
| fall_pc_i | input | DW | Address of the following instruction |
| mem_rdata_i | input | DW | Data-memory read value, same cycle |
| mem_addr_o | output | DW | Data-memory address |
| mem_wdata_o | output | DW | Data-memory write data |
| mem_we_o | output | 1 | Data-memory write enable |
| pc_next_o | output | DW | Selected next PC |

## Verification
A corrupted stack pointer shows up in the same cycle as a wrong `mem_addr_o` on the next push, pop, call or return. A corrupted general register shows up as wrong `mem_wdata_o` on the first push of that register. A lost or misrouted write-port update appears only later, when that register is pushed, so the sweeps push every register after loading it and after popping into it. Wrong next-PC selection is visible in the same cycle as the call or return, and a wrong return address shows up as `pc_next_o` on the matching return.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int RIDX_W = 4;
  localparam logic [RIDX_W-1:0] REG_NONE = '1;
  localparam logic [RIDX_W-1:0] REG_SP   = 4'd4;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDI  = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {VE_ZERO, VE_IMM, VE_SP_DN, VE_SP_UP} ve_sel_e;
  typedef enum logic [1:0] {AD_ZERO, AD_OLD_SP, AD_NEW_SP} adr_sel_e;
  typedef enum logic [1:0] {WD_ZERO, WD_REGA, WD_FALL} wd_sel_e;
  typedef enum logic [1:0] {PC_FALL, PC_IMM, PC_MEM} pc_sel_e;

  typedef struct packed {
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst_e;
    logic [RIDX_W-1:0] dst_m;
    ve_sel_e           ve;
    adr_sel_e          adr;
    wd_sel_e           wd;
    logic              mem_we;
    pc_sel_e           pc;
  } ctl_t;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  op_e               op,
  input  logic [RIDX_W-1:0] rsel,
  output ctl_t              ctl
);
  always_comb begin
    ctl = '{src_a: REG_NONE, src_b: REG_NONE, dst_e: REG_NONE, dst_m: REG_NONE,
            ve: VE_ZERO, adr: AD_ZERO, wd: WD_ZERO, mem_we: 1'b0, pc: PC_FALL};
    unique case (op)
      OP_LDI: begin
        ctl.dst_e = rsel;
        ctl.ve    = VE_IMM;
      end
      OP_PUSH: begin
        ctl.src_a  = rsel;
        ctl.src_b  = REG_SP;
        ctl.dst_e  = REG_SP;
        ctl.ve     = VE_SP_DN;
        ctl.adr    = AD_NEW_SP;
        ctl.wd     = WD_REGA;
        ctl.mem_we = 1'b1;
      end
      OP_POP: begin
        ctl.src_b = REG_SP;
        ctl.dst_e = REG_SP;
        ctl.dst_m = rsel;
        ctl.ve    = VE_SP_UP;
        ctl.adr   = AD_OLD_SP;
      end
      OP_CALL: begin
        ctl.src_b  = REG_SP;
        ctl.dst_e  = REG_SP;
        ctl.ve     = VE_SP_DN;
        ctl.adr    = AD_NEW_SP;
        ctl.wd     = WD_FALL;
        ctl.mem_we = 1'b1;
        ctl.pc     = PC_IMM;
      end
      OP_RET: begin
        ctl.src_b = REG_SP;
        ctl.dst_e = REG_SP;
        ctl.ve    = VE_SP_UP;
        ctl.adr   = AD_OLD_SP;
        ctl.pc    = PC_MEM;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile
  import stk_pkg::*;
#(
  parameter int          DW       = 64,
  parameter logic [DW-1:0] SP_RESET = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] rd_a_idx,
  input  logic [RIDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]     rd_a_val,
  output logic [DW-1:0]     rd_b_val,
  input  logic [RIDX_W-1:0] wr_e_idx,
  input  logic [DW-1:0]     wr_e_val,
  input  logic [RIDX_W-1:0] wr_m_idx,
  input  logic [DW-1:0]     wr_m_val,
  output logic [DW-1:0]     sp_q
);
  localparam int NREG = (1 << RIDX_W) - 1;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == int'(REG_SP)) ? SP_RESET : '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_m_idx == i[RIDX_W-1:0])      regs[i] <= wr_m_val;
        else if (wr_e_idx == i[RIDX_W-1:0]) regs[i] <= wr_e_val;
      end
    end
  end

  always_comb begin
    rd_a_val = '0;
    rd_b_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_a_idx == i[RIDX_W-1:0]) rd_a_val = regs[i];
      if (rd_b_idx == i[RIDX_W-1:0]) rd_b_val = regs[i];
    end
  end

  assign sp_q = regs[REG_SP];

  AST_M_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_m_idx == REG_SP && wr_e_idx == REG_SP) |=> sp_q == $past(wr_m_val)); // R5
  AST_NONE_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_m_idx == REG_NONE && wr_e_idx == REG_NONE) |=> $stable(sp_q)); // R9
endmodule

// File: rtl/stk_memsel.sv
module stk_memsel
  import stk_pkg::*;
#(
  parameter int DW = 64
) (
  input  ctl_t          ctl,
  input  logic [DW-1:0] old_sp,
  input  logic [DW-1:0] new_sp,
  input  logic [DW-1:0] reg_a,
  input  logic [DW-1:0] fall_pc,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic [DW-1:0] pc_next
);
  always_comb begin
    unique case (ctl.adr)
      AD_OLD_SP: addr = old_sp;
      AD_NEW_SP: addr = new_sp;
      default:   addr = '0;
    endcase
    unique case (ctl.wd)
      WD_REGA: wdata = reg_a;
      WD_FALL: wdata = fall_pc;
      default: wdata = '0;
    endcase
    unique case (ctl.pc)
      PC_IMM:  pc_next = imm;
      PC_MEM:  pc_next = rdata;
      default: pc_next = fall_pc;
    endcase
  end
  assign we = ctl.mem_we;
endmodule

// File: rtl/stk_ctl.sv
module stk_ctl
  import stk_pkg::*;
#(
  parameter int            DW       = 64,
  parameter logic [DW-1:0] SP_RESET = 'h200,
  parameter int            STEP     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [RIDX_W-1:0] reg_i,
  input  logic [DW-1:0]     imm_i,
  input  logic [DW-1:0]     fall_pc_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     pc_next_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  function automatic logic [DW-1:0] sp_dn(input logic [DW-1:0] sp);
    return sp - STEP_V;
  endfunction
  function automatic logic [DW-1:0] sp_up(input logic [DW-1:0] sp);
    return sp + STEP_V;
  endfunction

  op_e           op;
  ctl_t          ctl;
  logic [DW-1:0] val_a, val_b, val_e, sp_q;
  logic          is_push_like, is_pop_like;

  assign op           = op_e'(op_i);
  assign is_push_like = (op == OP_PUSH) || (op == OP_CALL);
  assign is_pop_like  = (op == OP_POP)  || (op == OP_RET);

  stk_decode u_dec (.op(op), .rsel(reg_i), .ctl(ctl));

  stk_regfile #(.DW(DW), .SP_RESET(SP_RESET)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ctl.src_a), .rd_b_idx(ctl.src_b),
    .rd_a_val(val_a), .rd_b_val(val_b),
    .wr_e_idx(ctl.dst_e), .wr_e_val(val_e),
    .wr_m_idx(ctl.dst_m), .wr_m_val(mem_rdata_i),
    .sp_q(sp_q)
  );

  always_comb begin
    unique case (ctl.ve)
      VE_IMM:   val_e = imm_i;
      VE_SP_DN: val_e = sp_dn(val_b);
      VE_SP_UP: val_e = sp_up(val_b);
      default:  val_e = '0;
    endcase
  end

  stk_memsel #(.DW(DW)) u_ms (
    .ctl(ctl), .old_sp(val_b), .new_sp(val_e), .reg_a(val_a),
    .fall_pc(fall_pc_i), .imm(imm_i), .rdata(mem_rdata_i),
    .addr(mem_addr_o), .wdata(mem_wdata_o), .we(mem_we_o), .pc_next(pc_next_o)
  );

  AST_PUSH_ADDR_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    is_push_like |-> mem_addr_o == sp_q - STEP_V); // R3
  AST_POP_ADDR_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_pop_like |-> mem_addr_o == sp_q); // R4
  AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> is_push_like); // R8
  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    is_push_like |=> sp_q == $past(sp_q) - STEP_V); // R6
  AST_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET || (op == OP_POP && reg_i != REG_SP)) |=> sp_q == $past(sp_q) + STEP_V); // R7
  AST_RET_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET) |-> pc_next_o == mem_rdata_i); // R7
endmodule

// File: tb/sim_stk_ctl.sv
module sim_stk_ctl;
  localparam int          DW  = 64;
  localparam logic [63:0] SPR = 64'h200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [3:0]    rsel = 4'd0;
  logic [DW-1:0] imm = '0, fall = '0;
  logic [DW-1:0] rdata, addr, wdata, pcn;
  logic          we;

  logic [DW-1:0] bmem [128];
  logic [DW-1:0] m [15];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stk_ctl #(.DW(DW), .SP_RESET(SPR), .STEP(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .reg_i(rsel), .imm_i(imm),
    .fall_pc_i(fall), .mem_rdata_i(rdata), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_we_o(we), .pc_next_o(pcn)
  );

  assign rdata = bmem[addr[9:3]];
  always @(posedge clk) if (we) bmem[addr[9:3]] <= wdata;

  task automatic do_op(input logic [2:0] o, input logic [3:0] r,
                       input logic [63:0] im, input logic [63:0] fp, input string tag);
    logic [63:0] sp, va, e_ad, e_wd, e_pc, rd;
    logic        e_we;
    @(negedge clk);
    op = o; rsel = r; imm = im; fall = fp;
    #1;
    sp = m[4];
    va = (r == 4'hF) ? 64'd0 : m[r];
    e_ad = 0; e_wd = 0; e_we = 0; e_pc = fp;
    case (o)
      3'd2: begin e_ad = sp - 8; e_wd = va; e_we = 1; end
      3'd3: e_ad = sp;
      3'd4: begin e_ad = sp - 8; e_wd = fp; e_we = 1; e_pc = im; end
      3'd5: begin e_ad = sp; e_pc = bmem[sp[9:3]]; end
      default: ;
    endcase
    rd = bmem[e_ad[9:3]];
    n_run++;
    if (addr !== e_ad || wdata !== e_wd || we !== e_we || pcn !== e_pc) begin
      n_fail++;
      $display("FAIL %s op=%0d r=%0d: addr=%h wd=%h we=%b pc=%h expected addr=%h wd=%h we=%b pc=%h",
               tag, o, r, addr, wdata, we, pcn, e_ad, e_wd, e_we, e_pc);
    end
    @(posedge clk); #1;
    case (o)
      3'd1: if (r != 4'hF) m[r] = im;
      3'd2, 3'd4: m[4] = sp - 8;
      3'd3: begin m[4] = sp + 8; if (r != 4'hF) m[r] = rd; end
      3'd5: m[4] = sp + 8;
      default: ;
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) bmem[i] = 64'hA000 + 64'(i) * 3;
    for (int i = 0; i < 15; i++) m[i] = (i == 4) ? SPR : 64'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents seen through pushes (SP and a zero register)
    do_op(3'd2, 4'd4, 0, 64'h10, "R1");
    do_op(3'd2, 4'd0, 0, 64'h20, "R1");
    do_op(3'd2, 4'd9, 0, 64'h30, "R1");
    // R2: load every general register
    for (int r = 0; r < 15; r++)
      if (r != 4) do_op(3'd1, 4'(r), 64'h1111_0000_0101 * 64'(r + 1) + 7, 64'h40 + 64'(r), "R2");
    // R9: load to the no-register number
    do_op(3'd1, 4'hF, 64'hDEAD, 64'h80, "R9");
    // R3: push every register
    for (int r = 0; r < 15; r++) do_op(3'd2, 4'(r), 0, 64'h100 + 64'(r), "R3");
    // R4 / R9: pop in reverse, discarding the slot of register 4
    for (int r = 14; r >= 0; r--) do_op(3'd3, (r == 4) ? 4'hF : 4'(r), 0, 64'h200, "R4");
    for (int r = 0; r < 15; r++) do_op(3'd2, 4'(r), 0, 64'h300, "R4");
    // R5: pop into the stack pointer
    do_op(3'd1, 4'd1, 64'h100, 64'h400, "R2");
    do_op(3'd2, 4'd1, 0, 64'h404, "R3");
    do_op(3'd3, 4'd4, 0, 64'h408, "R5");
    do_op(3'd2, 4'd4, 0, 64'h40C, "R5");
    // R6 / R7: nested calls then returns
    for (int k = 0; k < 8; k++) do_op(3'd4, 4'd0, 64'h4000 + 64'(k) * 64'h40, 64'h1000 + 64'(k) * 9, "R6");
    for (int k = 0; k < 8; k++) do_op(3'd5, 4'd0, 64'h7777, 64'h5000, "R7");
    // R8 / R10: inert opcodes, then push every register to show nothing changed
    for (int r = 0; r < 16; r++) begin
      do_op(3'd0, 4'(r), 64'h55, 64'h600, "R10");
      do_op(3'd6, 4'(r), 64'h66, 64'h604, "R10");
      do_op(3'd7, 4'(r), 64'h77, 64'h608, "R8");
    end
    for (int r = 0; r < 15; r++) do_op(3'd2, 4'(r), 0, 64'h700, "R10");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule